// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD bytes. A free-running enable at 32.768 kHz feeds a binary prescaler. Each time the prescaler wraps, it emits a one-cycle 1 Hz step, and that step advances seven fields: seconds, minutes, hours, day of week, date, month and a two-digit year. All carries resolve in the same clock cycle. Hours can run in a 24-hour format or in a 12-hour format with a meridiem flag. The date wraps at the true end of each month, and the calendar treats February of years divisible by four as 29 days long.

Software or a bus adapter loads the fields through a single-cycle write port. The port has a field select, a data byte and a strobe, and it accepts every write at once, so it has no handshake and no back-pressure. The live field values appear on parallel byte outputs. Bit 7 of the seconds byte is a halt control that freezes the time. Writing the seconds byte restarts the sub-second count, so the next step arrives exactly one full prescaler period after that write.

Top module: `bcd_timekeeper`

## Requirements
- R1: Reset loads seconds 00, minutes 00, hours 00 in 24-hour form, day of week 1, date 01, month 01 and year 00, with halt clear.
- R2: The seconds field advances by one BCD count once per 2^PRESC_W cycles in which osc_en is high, with the tens digit taking the carry from 9. Cycles with osc_en low do not count.
- R3: A write to the seconds field (select code 0) clears the prescaler. The first advance after it occurs on the 2^PRESC_W-th enabled clock edge after the write edge.
- R4: While bit 7 of the seconds field is 1, no field advances.
- R5: Seconds roll over from 59 to 00 and carry into minutes. Minutes roll over from 59 to 00 and carry into hours.
- R6: With hours bit 6 clear (24-hour form, bits 5:0 holding 00-23), hour 23 rolls over to 00 and advances the day of week and the date.
- R7: With hours bit 6 set (12-hour form, bit 5 = 1 for PM, bits 4:0 holding 01-12), the sequence runs 11 AM to 12 PM, then 12 PM to 1 PM, and 11 PM to 12 AM. Only the last of these advances the day.
- R8: The day of week counts 1 to 7 and wraps from 7 to 1 at the start of a new day.
- R9: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The month advances at that wrap.
- R10: February wraps after 29 when the two-digit year is divisible by four (00 included) and after 28 otherwise.
- R11: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R12: Select codes 0 to 6 address seconds, minutes, hours, day of week, date, month and year. The write stores only the defined bits: all 8 bits for seconds and year, bits 6:0 for minutes and hours, bits 2:0 for day of week, 5:0 for date and 4:0 for month; all other bits read 0. Code 7 changes nothing. A write to a field overrides that field's advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | 32.768 kHz count enable, one cycle wide |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code |
| wr_data | input | 8 | Packed BCD value to store |
| sec_o | output | 8 | Halt bit and seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with mode and meridiem bits |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench aims at each carry boundary in turn. It covers 9 to 10 inside a digit, the last second of a day in both hour formats, the 12-hour noon and midnight crossings, and the ends of 30-day and 31-day months. For February it uses years 00, 10, 12, 23 and 24, so that a leap test that looked only at the units digit, or that skipped 00, would land on the wrong day. A prescaler that was not cleared by a seconds write would advance one edge early or late. A wrong write priority would let the carry overwrite a field written on the stepping edge. A faulty halt would let the fields drift.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int FSEL_W     = 3;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  // one BCD count upward on a two-digit packed value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] hi;
    logic [3:0] lo;
    if (v[3:0] == 4'd9) begin
      hi = v[7:4] + 4'd1;
      lo = 4'd0;
    end else begin
      hi = v[7:4];
      lo = v[3:0] + 4'd1;
    end
    return {hi, lo};
  endfunction

  // two-digit year divisible by four: 2*tens + units must be a multiple of 4
  function automatic logic year_is_leap(input logic [7:0] y);
    logic units_even4;
    logic units_odd2;
    units_even4 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    units_odd2  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? units_odd2 : units_even4;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      F_SEC, F_YEAR:  return 8'hFF;
      F_MIN, F_HOUR:  return 8'h7F;
      F_DOW:          return 8'h07;
      F_DATE:         return 8'h3F;
      F_MONTH:        return 8'h1F;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int idx);
    case (idx)
      F_DOW, F_DATE, F_MONTH: return 8'h01;
      default:                return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic halt,
  input  logic clr,
  output logic tick
);
  localparam logic [PRESC_W-1:0] CNT_LAST = '1;

  logic [PRESC_W-1:0] cnt_q;
  logic               run;

  assign run  = osc_en && !halt;
  assign tick = run && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tk_time_step.sv
module tk_time_step
  import tk_pkg::*;
(
  input  logic [6:0] sec_q,
  input  logic [6:0] min_q,
  input  logic [6:0] hour_q,
  output logic [6:0] sec_nx,
  output logic [6:0] min_nx,
  output logic [6:0] hour_nx,
  output logic       day_carry
);
  logic       sec_wrap;
  logic       min_wrap;
  logic       mode12;
  logic       pm;
  logic [7:0] h12;
  logic [7:0] h24;
  logic [7:0] s_inc;
  logic [7:0] m_inc;
  logic [7:0] h_inc;

  assign mode12   = hour_q[6];
  assign pm       = hour_q[5];
  assign h12      = {3'b000, hour_q[4:0]};
  assign h24      = {2'b00, hour_q[5:0]};
  assign sec_wrap = (sec_q == 7'h59);
  assign min_wrap = sec_wrap && (min_q == 7'h59);
  assign s_inc    = bcd_inc({1'b0, sec_q});
  assign m_inc    = bcd_inc({1'b0, min_q});

  always_comb begin
    sec_nx = sec_wrap ? 7'h00 : s_inc[6:0];
    min_nx = min_q;
    if (sec_wrap) min_nx = (min_q == 7'h59) ? 7'h00 : m_inc[6:0];
  end

  always_comb begin
    hour_nx   = hour_q;
    day_carry = 1'b0;
    h_inc     = mode12 ? bcd_inc(h12) : bcd_inc(h24);
    if (min_wrap) begin
      if (mode12) begin
        if (h12 == 8'h12) begin
          hour_nx = {1'b1, pm, 5'h01};
        end else if (h12 == 8'h11) begin
          hour_nx   = {1'b1, !pm, 5'h12};
          day_carry = pm;
        end else begin
          hour_nx = {1'b1, pm, h_inc[4:0]};
        end
      end else begin
        if (h24 == 8'h23) begin
          hour_nx   = 7'h00;
          day_carry = 1'b1;
        end else begin
          hour_nx = {1'b0, h_inc[5:0]};
        end
      end
    end
  end
endmodule

// File: rtl/tk_date_step.sv
module tk_date_step
  import tk_pkg::*;
(
  input  logic       day_carry,
  input  logic [2:0] dow_q,
  input  logic [5:0] date_q,
  input  logic [4:0] month_q,
  input  logic [7:0] year_q,
  output logic [2:0] dow_nx,
  output logic [5:0] date_nx,
  output logic [4:0] month_nx,
  output logic [7:0] year_nx
);
  logic [7:0] last_day;
  logic [7:0] d_inc;
  logic [7:0] m_inc;
  logic       month_wrap;
  logic       year_wrap;

  assign last_day   = month_last_day({3'b000, month_q}, year_is_leap(year_q));
  assign d_inc      = bcd_inc({2'b00, date_q});
  assign m_inc      = bcd_inc({3'b000, month_q});
  assign month_wrap = day_carry && ({2'b00, date_q} == last_day);
  assign year_wrap  = month_wrap && (month_q == 5'h12);

  always_comb begin
    dow_nx   = dow_q;
    date_nx  = date_q;
    month_nx = month_q;
    year_nx  = year_q;
    if (day_carry) begin
      dow_nx  = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      date_nx = month_wrap ? 6'h01 : d_inc[5:0];
    end
    if (month_wrap) month_nx = year_wrap ? 5'h01 : m_inc[4:0];
    if (year_wrap)  year_nx  = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              wr_en,
  input  logic [FSEL_W-1:0] wr_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        dow_o,
  output logic [7:0]        date_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o
);
  logic [7:0] field_q  [NUM_FIELDS];
  logic [7:0] field_nx [NUM_FIELDS];
  logic       sec_tick;
  logic       sec_wr;
  logic       day_carry;
  logic [6:0] sec_nx7;
  logic [6:0] min_nx7;
  logic [6:0] hour_nx7;
  logic [2:0] dow_nx3;
  logic [5:0] date_nx6;
  logic [4:0] month_nx5;
  logic [7:0] year_nx8;

  assign sec_wr = wr_en && (wr_sel == FSEL_W'(F_SEC));

  tk_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .halt   (field_q[F_SEC][7]),
    .clr    (sec_wr),
    .tick   (sec_tick)
  );

  tk_time_step u_time (
    .sec_q     (field_q[F_SEC][6:0]),
    .min_q     (field_q[F_MIN][6:0]),
    .hour_q    (field_q[F_HOUR][6:0]),
    .sec_nx    (sec_nx7),
    .min_nx    (min_nx7),
    .hour_nx   (hour_nx7),
    .day_carry (day_carry)
  );

  tk_date_step u_date (
    .day_carry (day_carry),
    .dow_q     (field_q[F_DOW][2:0]),
    .date_q    (field_q[F_DATE][5:0]),
    .month_q   (field_q[F_MONTH][4:0]),
    .year_q    (field_q[F_YEAR]),
    .dow_nx    (dow_nx3),
    .date_nx   (date_nx6),
    .month_nx  (month_nx5),
    .year_nx   (year_nx8)
  );

  assign field_nx[F_SEC]   = {field_q[F_SEC][7], sec_nx7};
  assign field_nx[F_MIN]   = {1'b0, min_nx7};
  assign field_nx[F_HOUR]  = {1'b0, hour_nx7};
  assign field_nx[F_DOW]   = {5'b0, dow_nx3};
  assign field_nx[F_DATE]  = {2'b0, date_nx6};
  assign field_nx[F_MONTH] = {3'b0, month_nx5};
  assign field_nx[F_YEAR]  = year_nx8;

  // one register per field; a write to the field wins over its advance
  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en && (wr_sel == FSEL_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= field_reset(gi);
      else if (hit)      q <= wr_data & field_mask(gi);
      else if (sec_tick) q <= field_nx[gi] & field_mask(gi);
    end
    assign field_q[gi] = q;
  end

  assign sec_o   = field_q[F_SEC];
  assign min_o   = field_q[F_MIN];
  assign hour_o  = field_q[F_HOUR];
  assign dow_o   = field_q[F_DOW];
  assign date_o  = field_q[F_DATE];
  assign month_o = field_q[F_MONTH];
  assign year_o  = field_q[F_YEAR];
endmodule

// File: rtl/tk_checker.sv
module tk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic       tick,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  // R2: seconds only move on a step or a write
  a_r2_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sec_o));

  // R3: a seconds write restarts the sub-second count
  a_r3_wr_clears_presc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> !tick);

  // R4: halted time stays frozen
  a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> ($stable(sec_o) && $stable(min_o) &&
                              $stable(hour_o) && $stable(date_o)));

  // R6: 24-hour midnight rollover advances the day
  a_r6_midnight_24h: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23)
    |=> (hour_o == 8'h00 && sec_o == 8'h00 && dow_o != $past(dow_o)));

  // R7: 11 PM rolls to 12 AM in 12-hour form
  a_r7_midnight_12h: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h71)
    |=> (hour_o == 8'h52 && dow_o != $past(dow_o)));

  // R11: last second of the year wraps the whole calendar
  a_r11_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     date_o == 8'h31 && month_o == 8'h12 && year_o == 8'h99)
    |=> (year_o == 8'h00 && month_o == 8'h01 && date_o == 8'h01));
endmodule

bind bcd_timekeeper tk_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .tick    (sec_tick),
  .sec_o   (sec_o),
  .min_o   (min_o),
  .hour_o  (hour_o),
  .dow_o   (dow_o),
  .date_o  (date_o),
  .month_o (month_o),
  .year_o  (year_o)
);

// File: tb/sim_bcd_timekeeper.sv
module sim_bcd_timekeeper;
  localparam int PW    = 4;
  localparam int STEPS = 1 << PW;
  localparam int NV    = 16;

  // packed {year, month, date, dow, hour, min, sec}
  localparam logic [55:0] VIN [NV] = '{
    56'h24_03_15_03_10_20_08,   // R2
    56'h24_03_15_03_10_20_09,   // R2
    56'h24_03_15_03_10_14_59,   // R5
    56'h24_03_15_03_09_59_59,   // R6
    56'h24_03_15_07_23_59_59,   // R6 R8
    56'h24_03_15_03_51_59_59,   // R7
    56'h24_03_15_03_72_59_59,   // R7
    56'h24_03_10_02_71_59_59,   // R7
    56'h24_04_30_02_23_59_59,   // R9
    56'h24_01_31_02_23_59_59,   // R9
    56'h23_02_28_02_23_59_59,   // R10
    56'h24_02_28_02_23_59_59,   // R10
    56'h00_02_29_02_23_59_59,   // R10
    56'h10_02_28_02_23_59_59,   // R10
    56'h12_02_28_02_23_59_59,   // R10
    56'h99_12_31_02_23_59_59    // R11
  };
  localparam logic [55:0] VEXP [NV] = '{
    56'h24_03_15_03_10_20_09,
    56'h24_03_15_03_10_20_10,
    56'h24_03_15_03_10_15_00,
    56'h24_03_15_03_10_00_00,
    56'h24_03_16_01_00_00_00,
    56'h24_03_15_03_72_00_00,
    56'h24_03_15_03_61_00_00,
    56'h24_03_11_03_52_00_00,
    56'h24_05_01_03_00_00_00,
    56'h24_02_01_03_00_00_00,
    56'h23_03_01_03_00_00_00,
    56'h24_02_29_03_00_00_00,
    56'h00_03_01_03_00_00_00,
    56'h10_03_01_03_00_00_00,
    56'h12_02_29_03_00_00_00,
    56'h00_01_01_03_00_00_00
  };
  localparam int VREQ [NV] = '{2, 2, 5, 6, 6, 7, 7, 7, 9, 9, 10, 10, 10, 10, 10, 11};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic [55:0] now;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.PRESC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  assign now = {year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};

  task automatic chk(input string tag, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // halt, load every field, then release with the seconds value
  task automatic load(input logic [55:0] v);
    wr(3'd0, 8'h80);
    wr(3'd1, v[15:8]);
    wr(3'd2, v[23:16]);
    wr(3'd3, v[31:24]);
    wr(3'd4, v[39:32]);
    wr(3'd5, v[47:40]);
    wr(3'd6, v[55:48]);
    wr(3'd0, v[7:0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1", now, 56'h00_01_01_01_00_00_00);

    for (int i = 0; i < NV; i++) begin
      load(VIN[i]);
      repeat (STEPS) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d", VREQ[i], i), now, VEXP[i]);
    end

    // R3: the advance lands exactly STEPS edges after a seconds write
    wr(3'd0, 8'h30);
    repeat (STEPS - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 early", {48'h0, sec_o}, 56'h30);
    @(posedge clk);
    @(negedge clk);
    chk("R3 on time", {48'h0, sec_o}, 56'h31);

    // R2: enable low stalls the prescaler
    wr(3'd0, 8'h10);
    osc_en = 1'b0;
    repeat (3 * STEPS) @(posedge clk);
    @(negedge clk);
    chk("R2 stalled", {48'h0, sec_o}, 56'h10);
    osc_en = 1'b1;
    repeat (STEPS) @(posedge clk);
    @(negedge clk);
    chk("R2 resumed", {48'h0, sec_o}, 56'h11);

    // R4: halt freezes every field
    load(56'h24_06_30_05_23_59_59);
    wr(3'd0, 8'hD9);
    repeat (4 * STEPS) @(posedge clk);
    @(negedge clk);
    chk("R4 halted", now, 56'h24_06_30_05_23_59_D9);

    // R12: masking and the unused select code
    wr(3'd3, 8'hFF);
    @(negedge clk);
    chk("R12 mask", {48'h0, dow_o}, 56'h07);
    wr(3'd7, 8'h33);
    @(negedge clk);
    chk("R12 sel7", now, 56'h24_06_30_07_23_59_D9);

    // R12: a write on the stepping edge overrides the carry into minutes
    load(56'h24_06_15_02_08_10_59);
    repeat (STEPS - 1) @(posedge clk);
    wr(3'd1, 8'h30);
    @(negedge clk);
    chk("R12 write wins", now, 56'h24_06_15_02_08_30_00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule